// File: doc/BRIEF.md
# Phase-Correct PWM Timer

An 8-bit timer/counter driven by a selectable clock prescaler. It has one compare value and one waveform output. Three counting modes are available. Free-running mode counts up and wraps. Clear-on-match mode restarts from zero once the count has reached the compare value. Phase-correct mode counts up to the top, then back down to zero, which produces a PWM waveform that is symmetric about the bottom of the count.

An overflow flag and a compare flag report the timer events. Software clears each flag by pulsing its clear input. In phase-correct mode the compare value is double-buffered, and the output level is derived from the counter position. As a result, the output takes the correct level at the endpoints even when no match occurs, for example when the compare value has just left the top value. A compare value of zero or of the top value holds the output constant.

The counting direction is kept by a two-state machine. `ST_RISE` and `ST_FALL` are its states. It has three transitions:
- turn-at-top: `ST_RISE` to `ST_FALL`, on a tick with the count at the top.
- turn-at-bottom: `ST_FALL` to `ST_RISE`, on a tick with the count at zero.
- leave-pwm: any state to `ST_RISE`, whenever the mode is not phase-correct.

Top module: `pwm_phase_timer`

## Requirements
- R1: During reset and right after it, the count is 0, the output is low and both flags are clear.
- R2: In free-running mode (mode 2'b00, and the unused code 2'b11 behaves the same) every tick adds one to the count, and the count wraps from 255 to 0.
- R3: In free-running mode the overflow flag sets on the tick that wraps the count from 255 to 0.
- R4: The compare flag sets on the tick that leaves a count equal to the active compare value.
- R5: A one-cycle high pulse on a clear input clears its flag. A set event in the same cycle wins over the clear.
- R6: In clear-on-match mode (mode 2'b01), a tick with the count equal to the compare value loads 0 into the count and sets the compare flag.
- R7: In phase-correct mode (mode 2'b10), the count goes 0,1,...,254,255,254,...,1,0,1,... Each endpoint lasts exactly one tick.
- R8: In phase-correct mode the overflow flag sets on the tick that brings the count down to 0.
- R9: In free-running and clear-on-match modes, a new compare value acts at once. In phase-correct mode the active value is reloaded only on the tick that brings the count to 255, and also in the first cycle of the mode, including after reset.
- R10: Outside phase-correct mode, the output toggles on each compare match, and the invert input has no effect.
- R11: In phase-correct mode with the invert input low, the output after each tick is high exactly when the new count is below the active compare value.
- R12: In phase-correct mode a compare value of 0 keeps the output low, and a value of 255 keeps it high. When the value changes away from 255, the output falls on the reload tick at the top, with no match.
- R13: In phase-correct mode with the invert input high, the output is the complement of the R11 and R12 level.
- R14: The prescaler select picks the system clocks per tick. The codes are 0 = stopped, 1 = 1, 2 = 8, 3 = 32, 4 = 64, 5 = 128, 6 = 256, 7 = 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 free-running, 01 clear-on-match, 10 phase-correct, 11 as 00 |
| inv_out | input | 1 | Inverts the phase-correct output |
| pre_sel | input | 3 | Prescaler select (R14) |
| cmp_val | input | 8 | Compare value |
| ovf_clr | input | 1 | Clears the overflow flag when high |
| cmp_clr | input | 1 | Clears the compare flag when high |
| count | output | 8 | Counter value |
| wave | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |

## Verification
The bench builds the timer with its default parameters: an 8-bit counter and a 10-bit prescaler. At these sizes a full 510-tick phase-correct period fits in a short run, so both turn-around points, the bottom overflow and the reload at the top are reached in every phase-correct scenario. The largest divide ratio of 1024 is also reachable, so every prescaler code is checked at its first tick edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Counting modes
    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_CTC  = 2'b01,
        MODE_PC   = 2'b10,
        MODE_RSVD = 2'b11
    } tmode_e;

    // Direction state of the phase-correct counter
    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } dir_e;

    // Width of the free-running prescaler counter (largest ratio 2**10)
    localparam int PRE_W = 10;

    // log2 of the divide ratio for each select code; code 0 is unused (stopped)
    function automatic int unsigned div_shift(input logic [2:0] sel);
        int unsigned sh;
        unique case (sel)
            3'd2:    sh = 3;
            3'd3:    sh = 5;
            3'd4:    sh = 6;
            3'd5:    sh = 7;
            3'd6:    sh = 8;
            3'd7:    sh = 10;
            default: sh = 0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        mask = PRE_W'((1 << div_shift(sel)) - 1);
        tick = (sel != 3'd0) && ((pre_q & mask) == mask);
    end
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_timer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] cmp_val,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic [CW-1:0] ocr_nxt,
    output logic          is_pc,
    output logic          ovf_evt,
    output logic          cmp_evt
);
    localparam logic [CW-1:0] CNT_TOP  = '1;
    localparam logic [CW-1:0] CNT_TURN = CNT_TOP - CW'(1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    dir_e          dir_q, dir_d;
    logic [CW-1:0] ocr_q;
    logic [CW-1:0] ocr_act;
    logic          pc_live_q;
    logic          top_load;
    logic          load_any;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= ST_RISE;
            cnt_q     <= '0;
            ocr_q     <= '0;
            pc_live_q <= 1'b0;
        end else begin
            dir_q     <= dir_d;
            cnt_q     <= cnt_d;
            pc_live_q <= is_pc;
            if (load_any) ocr_q <= cmp_val;
        end
    end

    // Next state and events
    always_comb begin
        is_pc    = (tmode_e'(mode) == MODE_PC);
        ocr_act  = (is_pc && pc_live_q) ? ocr_q : cmp_val;
        dir_d    = dir_q;
        cnt_d    = cnt_q;
        ovf_evt  = 1'b0;
        cmp_evt  = 1'b0;
        top_load = 1'b0;
        if (!is_pc) dir_d = ST_RISE;              // leave-pwm
        if (tick) begin
            cmp_evt = (cnt_q == ocr_act);
            unique case (tmode_e'(mode))
                MODE_CTC: begin
                    cnt_d   = cmp_evt ? '0 : cnt_q + CNT_ONE;
                    ovf_evt = (cnt_q == CNT_TOP);
                end
                MODE_PC: begin
                    unique case (dir_q)
                        ST_RISE: begin
                            if (cnt_q == CNT_TOP) begin
                                cnt_d = CNT_TURN;
                                dir_d = ST_FALL;      // turn-at-top
                            end else begin
                                cnt_d    = cnt_q + CNT_ONE;
                                top_load = (cnt_q == CNT_TURN);
                            end
                        end
                        ST_FALL: begin
                            if (cnt_q == '0) begin
                                cnt_d = CNT_ONE;
                                dir_d = ST_RISE;      // turn-at-bottom
                            end else begin
                                cnt_d   = cnt_q - CNT_ONE;
                                ovf_evt = (cnt_q == CNT_ONE);
                            end
                        end
                        default: cnt_d = cnt_q;
                    endcase
                end
                default: begin
                    cnt_d   = cnt_q + CNT_ONE;
                    ovf_evt = (cnt_q == CNT_TOP);
                end
            endcase
        end
        load_any = !is_pc || !pc_live_q || top_load;
        ocr_nxt  = load_any ? cmp_val : ocr_q;
    end
endmodule

// File: rtl/pwm_wave_flags.sv
module pwm_wave_flags #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          is_pc,
    input  logic          inv_out,
    input  logic [CW-1:0] cnt_d,
    input  logic [CW-1:0] ocr_nxt,
    input  logic          ovf_evt,
    input  logic          cmp_evt,
    input  logic          ovf_clr,
    input  logic          cmp_clr,
    output logic          wave,
    output logic          ovf_flag,
    output logic          cmp_flag
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    logic pc_level;

    always_comb begin
        pc_level = (ocr_nxt == CNT_TOP) || (cnt_d < ocr_nxt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave     <= 1'b0;
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (tick) begin
                if (is_pc)        wave <= pc_level ^ inv_out;
                else if (cmp_evt) wave <= ~wave;
            end
            ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);
            cmp_flag <= cmp_evt | (cmp_flag & ~cmp_clr);
        end
    end
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          inv_out,
    input  logic [2:0]    pre_sel,
    input  logic [CW-1:0] cmp_val,
    input  logic          ovf_clr,
    input  logic          cmp_clr,
    output logic [CW-1:0] count,
    output logic          wave,
    output logic          ovf_flag,
    output logic          cmp_flag
);
    logic          tick;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] ocr_nxt;
    logic          is_pc;
    logic          ovf_evt;
    logic          cmp_evt;

    pwm_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (pre_sel),
        .tick  (tick)
    );

    pwm_count_core #(.CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode),
        .cmp_val (cmp_val),
        .cnt_q   (count),
        .cnt_d   (cnt_d),
        .ocr_nxt (ocr_nxt),
        .is_pc   (is_pc),
        .ovf_evt (ovf_evt),
        .cmp_evt (cmp_evt)
    );

    pwm_wave_flags #(.CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .is_pc    (is_pc),
        .inv_out  (inv_out),
        .cnt_d    (cnt_d),
        .ocr_nxt  (ocr_nxt),
        .ovf_evt  (ovf_evt),
        .cmp_evt  (cmp_evt),
        .ovf_clr  (ovf_clr),
        .cmp_clr  (cmp_clr),
        .wave     (wave),
        .ovf_flag (ovf_flag),
        .cmp_flag (cmp_flag)
    );
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [2:0]    pre_sel,
    input logic [CW-1:0] cmp_val,
    input logic [CW-1:0] count,
    input logic          ovf_flag
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $past(mode) == 2'b00)
        |-> (count == $past(count) || count == CW'($past(count) + 1)));

    a_r3_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $past(mode) == 2'b00 && $rose(ovf_flag))
        |-> ($past(count) == CNT_TOP && count == '0));

    a_r6_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b01 && $past(count) == $past(cmp_val)
         && count != $past(count))
        |-> (count == '0));

    a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10)
        |-> (count == $past(count) || count == CW'($past(count) + 1)
             || count == CW'($past(count) - 1)));

    a_r7_pc_top_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10 && $past(count) == CNT_TOP
         && count != CNT_TOP)
        |-> (count == CW'(CNT_TOP - 1)));

    a_r8_pc_bottom_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10 && $rose(ovf_flag))
        |-> (count == '0));

    a_r14_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel == 3'd0 && $past(pre_sel) == 3'd0) |-> $stable(count));
endmodule

bind pwm_phase_timer pwm_timer_checker #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .pre_sel  (pre_sel),
    .cmp_val  (cmp_val),
    .count    (count),
    .ovf_flag (ovf_flag)
);

// File: tb/tb_pwm_phase_timer.sv
module tb_pwm_phase_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       inv_out = 1'b0;
    logic [2:0] pre_sel = 3'd1;
    logic [7:0] cmp_val = 8'd0;
    logic       ovf_clr = 1'b0;
    logic       cmp_clr = 1'b0;
    logic [7:0] count;
    logic       wave;
    logic       ovf_flag;
    logic       cmp_flag;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    total = 0;
    bit    done = 1'b0;

    // scoreboard queues: stamp, kind (0 count, 1 wave, 2 ovf, 3 cmp), value, tag
    int    q_stamp[$];
    int    q_kind[$];
    int    q_exp[$];
    string q_req[$];

    always #2.5 clk = ~clk;   // 200 MHz

    pwm_phase_timer dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .inv_out(inv_out),
        .pre_sel(pre_sel), .cmp_val(cmp_val), .ovf_clr(ovf_clr),
        .cmp_clr(cmp_clr), .count(count), .wave(wave),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int stamp, input int kind, input int val, input string req);
        q_stamp.push_back(stamp);
        q_kind.push_back(kind);
        q_exp.push_back(val);
        q_req.push_back(req);
    endtask

    function automatic int observe(input int kind);
        case (kind)
            0:       return int'(count);
            1:       return int'(wave);
            2:       return int'(ovf_flag);
            default: return int'(cmp_flag);
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: counts ticks since reset release and pops due items
    initial begin
        forever begin
            @(posedge clk);
            total++;
            if (!rst_n) cyc = 0;
            else        cyc++;
            #2;
            if (rst_n) begin
                for (int i = q_stamp.size() - 1; i >= 0; i--) begin
                    if (q_stamp[i] <= cyc) begin
                        if (q_stamp[i] == cyc)
                            chk(q_req[i], $sformatf("kind %0d @%0d", q_kind[i], cyc),
                                observe(q_kind[i]), q_exp[i]);
                        else
                            chk(q_req[i], "missed sample", 0, 1);
                        q_stamp.delete(i);
                        q_kind.delete(i);
                        q_exp.delete(i);
                        q_req.delete(i);
                    end
                end
            end
            if (total > 150000) begin
                chk("WATCHDOG", "run length", total, 150000);
                summary();
            end
        end
    end

    task automatic start(input logic [1:0] m, input logic iv, input logic [2:0] ps,
                         input logic [7:0] cv);
        @(negedge clk);
        rst_n   = 1'b0;
        mode    = m;
        inv_out = iv;
        pre_sel = ps;
        cmp_val = cv;
        ovf_clr = 1'b0;
        cmp_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset count", int'(count), 0);
        chk("R1", "reset wave", int'(wave), 0);
        chk("R1", "reset ovf", int'(ovf_flag), 0);
        chk("R1", "reset cmp", int'(cmp_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    task automatic finish_scn(input int last);
        while (cyc < last + 1) @(negedge clk);
        chk("SB", "pending items", q_stamp.size(), 0);
    endtask

    initial begin
        // Free-running, invert high (R10: ignored), compare 10
        start(2'b00, 1'b1, 3'd1, 8'd10);
        push(5, 0, 5, "R2");
        push(255, 0, 255, "R2");
        push(256, 0, 0, "R2");
        push(257, 0, 1, "R2");
        push(255, 2, 0, "R3");
        push(256, 2, 1, "R3");
        push(10, 3, 0, "R4");
        push(11, 3, 1, "R4");
        push(10, 1, 0, "R10");
        push(11, 1, 1, "R10");
        push(21, 3, 0, "R5");
        push(261, 2, 0, "R5");
        push(267, 3, 1, "R5");
        push(267, 1, 0, "R10");
        wait_cyc(20);  cmp_clr = 1'b1; @(negedge clk); cmp_clr = 1'b0;
        wait_cyc(260); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        wait_cyc(266); cmp_clr = 1'b1; @(negedge clk); cmp_clr = 1'b0;
        finish_scn(267);

        // Clear-on-match, compare 5 then 2 (R6, R9 immediate)
        start(2'b01, 1'b0, 3'd1, 8'd5);
        push(5, 0, 5, "R6");
        push(5, 3, 0, "R6");
        push(6, 0, 0, "R6");
        push(6, 3, 1, "R6");
        push(7, 0, 1, "R6");
        push(12, 0, 0, "R6");
        push(6, 1, 1, "R10");
        push(12, 1, 0, "R10");
        push(12, 2, 0, "R6");
        push(14, 0, 2, "R9");
        push(15, 0, 0, "R9");
        wait_cyc(13); cmp_val = 8'd2;
        finish_scn(15);

        // Phase-correct, compare 100, then 200 written mid-period
        start(2'b10, 1'b0, 3'd1, 8'd100);
        push(1, 1, 1, "R11");
        push(99, 1, 1, "R11");
        push(100, 1, 0, "R11");
        push(101, 3, 1, "R4");
        push(254, 0, 254, "R7");
        push(255, 0, 255, "R7");
        push(256, 0, 254, "R7");
        push(509, 0, 1, "R7");
        push(510, 0, 0, "R7");
        push(511, 0, 1, "R7");
        push(509, 2, 0, "R8");
        push(510, 2, 1, "R8");
        push(410, 1, 0, "R9");
        push(411, 1, 1, "R11");
        push(660, 1, 0, "R9");
        push(765, 0, 255, "R7");
        push(820, 1, 0, "R9");
        push(821, 1, 1, "R9");
        wait_cyc(300); cmp_val = 8'd200;
        finish_scn(821);

        // Extremes (R12)
        start(2'b10, 1'b0, 3'd1, 8'd0);
        push(1, 1, 0, "R12");
        push(255, 1, 0, "R12");
        push(400, 1, 0, "R12");
        finish_scn(400);

        start(2'b10, 1'b0, 3'd1, 8'd255);
        push(1, 1, 1, "R12");
        push(255, 1, 1, "R12");
        push(400, 1, 1, "R12");
        push(764, 1, 1, "R12");
        push(765, 1, 0, "R12");
        push(970, 1, 0, "R12");
        push(971, 0, 49, "R12");
        push(971, 1, 1, "R12");
        wait_cyc(300); cmp_val = 8'd50;
        finish_scn(971);

        // Inverted (R13)
        start(2'b10, 1'b1, 3'd1, 8'd100);
        push(50, 1, 0, "R13");
        push(150, 1, 1, "R13");
        finish_scn(150);
        start(2'b10, 1'b1, 3'd1, 8'd0);
        push(10, 1, 1, "R13");
        finish_scn(10);

        // Prescaler codes (R14)
        start(2'b00, 1'b0, 3'd0, 8'd200);
        push(50, 0, 0, "R14");
        finish_scn(50);
        start(2'b00, 1'b0, 3'd2, 8'd200);
        push(7, 0, 0, "R14");
        push(8, 0, 1, "R14");
        push(16, 0, 2, "R14");
        finish_scn(16);
        start(2'b00, 1'b0, 3'd3, 8'd200);
        push(31, 0, 0, "R14");
        push(32, 0, 1, "R14");
        finish_scn(32);
        start(2'b00, 1'b0, 3'd4, 8'd200);
        push(63, 0, 0, "R14");
        push(64, 0, 1, "R14");
        finish_scn(64);
        start(2'b00, 1'b0, 3'd5, 8'd200);
        push(127, 0, 0, "R14");
        push(128, 0, 1, "R14");
        finish_scn(128);
        start(2'b00, 1'b0, 3'd6, 8'd200);
        push(255, 0, 0, "R14");
        push(256, 0, 1, "R14");
        finish_scn(256);
        start(2'b00, 1'b0, 3'd7, 8'd200);
        push(1023, 0, 0, "R14");
        push(1024, 0, 1, "R14");
        finish_scn(1024);

        summary();
    end
endmodule